// File: doc/BRIEF.md
# Output-Compare PWM Generator

This block is a timer-based pulse generator built around a W-bit counter that advances on a clock-enable tick. Software writes an on-time value and a cycle length through a small register write port. Both values go into hidden holding registers first. The comparators only ever look at the active copies, and those copies are refreshed only when the counter restarts. A new setting therefore always begins on a clean cycle boundary.

Two waveform shapes are available. In the edge-aligned shape the pin is high from the counter restart until the on-time compare. In the center-aligned shape the pin is high from the on-time compare until the cycle ends. The counter can restart on its own period compare, or it can free-run and restart on an external sync pulse or on wrap-around. A set of fault inputs takes over the pin at once, either driving a chosen level or releasing the pin to high impedance. The fault state stays latched until software clears it. An interrupt pulse marks each on-time compare and each newly latched fault.

Top module: `ocpwm_core`

## Requirements
- R1: With control bit 0 clear (edge shape) and no fault, pwm_out equals (counter < active on-time) XOR control bit 1. An on-time of 0 gives a constant low, and an on-time above the cycle length gives a constant high.
- R2: With control bit 0 set (center shape) and no fault, pwm_out equals (counter >= active on-time) XOR control bit 1. The pin is therefore low after each counter restart until the on-time compare.
- R3: A write to address 0 (on-time) or address 1 (cycle length) changes only a holding register. The active values take the holding values on the clock edge where the counter restarts, and at no other time.
- R4: With control bit 4 set (self-sync), the counter counts 0..P on ticks and restarts on the tick where it equals the active cycle length P, so one cycle lasts P+1 ticks. sync_in is ignored.
- R5: With control bit 4 clear, the counter restarts when sync_in is high (tick not needed) or on the tick where it holds its all-ones value.
- R6: While any fault_in bit is high, the pin is overridden in the same cycle. pwm_oe is 0 if control bit 3 is set, and pwm_out equals control bit 2.
- R7: Control bit 1 inverts the normal (non-fault) output.
- R8: A fault latches. A write to address 3 with data bit 0 set clears the latch only when no fault_in bit is high. The override then stays until the next counter restart, and normal output resumes after it.
- R9: irq is a one-cycle pulse on the clock edge after a tick on which the counter equals the active on-time. It also pulses on the edge after a fault input is seen while no fault is latched.
- R10: After reset the counter, holding registers, active registers, control register and fault state are all zero. This gives pwm_out=0, pwm_oe=1 and irq=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 on-time, 1 cycle length, 2 control, 3 fault clear |
| wr_data | input | W | Write data |
| tick | input | 1 | Counter advance enable |
| sync_in | input | 1 | External counter restart (control bit 4 clear) |
| fault_in | input | NF | Fault inputs, active high, any bit triggers |
| pwm_out | output | 1 | Pin level |
| pwm_oe | output | 1 | Pin drive enable (0 = high impedance) |
| irq | output | 1 | Compare/fault interrupt pulse |

## Verification
Random programs mix both shapes, invert on and off, short cycle lengths, sparse ticks and rewrites in mid-cycle. These runs separate a correct compare from an off-by-one in the count, and a shadowed update from one applied at once. Directed runs drive an on-time of zero and an on-time beyond the cycle, which separates the constant levels from a stray edge. A sync-driven run followed by a full wrap-around run separates the two restart sources. Fault runs assert inputs, attempt a clear while the input is still high, then release and clear. These runs show that the override is immediate, that the latch holds, and that output resumes only at the next cycle boundary.

// File: rtl/ocpwm_pkg.sv
`timescale 1ns/1ps
package ocpwm_pkg;
  localparam int CTRL_BITS = 5;

  localparam logic [1:0] ADDR_DUTY = 2'd0;
  localparam logic [1:0] ADDR_PER  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_CLR  = 2'd3;

  // bit 0 = center shape, 1 = invert, 2 = fault level, 3 = fault tristate, 4 = self-sync
  typedef struct packed {
    logic self_sync;
    logic flt_tris;
    logic flt_lvl;
    logic invert;
    logic center;
  } ocpwm_ctrl_t;

  // Raw waveform level before inversion
  function automatic logic wave_level(input logic center, input logic [31:0] tmr,
                                      input logic [31:0] duty);
    logic below;
    below = (tmr < duty);
    return center ? !below : below;
  endfunction
endpackage

// File: rtl/ocpwm_timebase.sv
`timescale 1ns/1ps
module ocpwm_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         sync_in,
  input  logic         self_sync,
  input  logic         duty_wr,
  input  logic         per_wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] tmr,
  output logic [W-1:0] duty_act,
  output logic         wrap,
  output logic         cmp_hit
);
  localparam logic [W-1:0] TMR_MAX = {W{1'b1}};

  logic [W-1:0] duty_buf, per_buf, per_act;
  logic         per_hit, roll_hit;

  assign per_hit  = tick && (tmr == per_act);
  assign roll_hit = tick && (tmr == TMR_MAX);
  assign wrap     = self_sync ? per_hit : (sync_in || roll_hit);
  assign cmp_hit  = tick && (tmr == duty_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_buf <= '0;
      per_buf  <= '0;
    end else begin
      if (duty_wr) duty_buf <= wr_data;
      if (per_wr)  per_buf  <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr      <= '0;
      duty_act <= '0;
      per_act  <= '0;
    end else if (wrap) begin
      tmr      <= '0;
      duty_act <= duty_buf;
      per_act  <= per_buf;
    end else if (tick) begin
      tmr <= tmr + 1'b1;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(duty_act) && $stable(per_act))); // R3
  AST_SELF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (self_sync && tick && tmr == per_act) |=> (tmr == '0)); // R4
  AST_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (!self_sync && tick && tmr == TMR_MAX) |=> (tmr == '0)); // R5
endmodule

// File: rtl/ocpwm_faultctl.sv
`timescale 1ns/1ps
module ocpwm_faultctl #(
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] fault_in,
  input  logic          clr_req,
  input  logic          wrap,
  output logic          forced,
  output logic          flt_new
);
  logic any_flt, latched, resume_wait, clr_ok;

  assign any_flt = |fault_in;
  assign flt_new = any_flt && !latched;
  assign clr_ok  = latched && clr_req && !any_flt;
  // Raw input acts without a clock edge; the latch and wait flag hold it after
  assign forced  = any_flt || latched || resume_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched     <= 1'b0;
      resume_wait <= 1'b0;
    end else begin
      if (any_flt)      latched <= 1'b1;
      else if (clr_req) latched <= 1'b0;
      if (clr_ok)       resume_wait <= 1'b1;
      else if (wrap)    resume_wait <= 1'b0;
    end
  end

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !clr_req) |=> latched); // R8
  AST_HOLD_TO_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (forced && !wrap) |=> forced); // R8
endmodule

// File: rtl/ocpwm_pinout.sv
`timescale 1ns/1ps
module ocpwm_pinout
  import ocpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  ocpwm_ctrl_t  ctrl,
  input  logic         forced,
  input  logic [W-1:0] tmr,
  input  logic [W-1:0] duty_act,
  output logic         pwm_out,
  output logic         pwm_oe
);
  logic wave;

  assign wave    = wave_level(ctrl.center, 32'(tmr), 32'(duty_act));
  assign pwm_out = forced ? ctrl.flt_lvl : (wave ^ ctrl.invert);
  assign pwm_oe  = !(forced && ctrl.flt_tris);
endmodule

// File: rtl/ocpwm_core.sv
`timescale 1ns/1ps
module ocpwm_core
  import ocpwm_pkg::*;
#(
  parameter int W  = 16,
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          tick,
  input  logic          sync_in,
  input  logic [NF-1:0] fault_in,
  output logic          pwm_out,
  output logic          pwm_oe,
  output logic          irq
);
  ocpwm_ctrl_t  ctrl;
  logic         duty_wr, per_wr, ctrl_wr, clr_req;
  logic [W-1:0] tmr, duty_act;
  logic         wrap, cmp_hit, forced, flt_new;

  assign duty_wr = wr_en && (wr_addr == ADDR_DUTY);
  assign per_wr  = wr_en && (wr_addr == ADDR_PER);
  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign clr_req = wr_en && (wr_addr == ADDR_CLR) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= ocpwm_ctrl_t'(wr_data[CTRL_BITS-1:0]);
  end

  ocpwm_timebase #(.W(W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sync_in(sync_in),
    .self_sync(ctrl.self_sync), .duty_wr(duty_wr), .per_wr(per_wr),
    .wr_data(wr_data), .tmr(tmr), .duty_act(duty_act),
    .wrap(wrap), .cmp_hit(cmp_hit)
  );

  ocpwm_faultctl #(.NF(NF)) u_flt (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .clr_req(clr_req),
    .wrap(wrap), .forced(forced), .flt_new(flt_new)
  );

  ocpwm_pinout #(.W(W)) u_pin (
    .ctrl(ctrl), .forced(forced), .tmr(tmr), .duty_act(duty_act),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= cmp_hit || flt_new;
  end

  AST_FAULT_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_in) |-> (ctrl.flt_tris ? !pwm_oe : (pwm_out == ctrl.flt_lvl))); // R6
  AST_IRQ_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    flt_new |=> irq); // R9
  AST_IRQ_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> irq); // R9
endmodule

// File: tb/ocpwm_core_tb_top.sv
`timescale 1ns/1ps
module ocpwm_core_tb_top;
  localparam int W  = 16;
  localparam int NF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          wr_en, tick, sync_in;
  logic [1:0]    wr_addr;
  logic [W-1:0]  wr_data;
  logic [NF-1:0] fault_in;
  logic          pwm_out, pwm_oe, irq;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  ocpwm_core #(.W(W), .NF(NF)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .sync_in(sync_in), .fault_in(fault_in),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe), .irq(irq)
  );

  // Reference state, built from the requirement text
  logic [W-1:0] m_tmr, m_dact, m_pact, m_dbuf, m_pbuf;
  logic [4:0]   m_ctrl;
  logic         m_lat, m_wait, m_irq;

  function automatic logic ref_wave(input logic ctr, input logic [W-1:0] t, input logic [W-1:0] d);
    if (ctr) return !(t < d);  // R2: high from compare to cycle end
    return (t < d);            // R1: high from restart to compare
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic restart, flt, clr;
    if (!rst_n) begin
      m_tmr <= '0; m_dact <= '0; m_pact <= '0; m_dbuf <= '0; m_pbuf <= '0;
      m_ctrl <= '0; m_lat <= 0; m_wait <= 0; m_irq <= 0;
    end else begin
      if (m_ctrl[4]) restart = tick && (m_tmr == m_pact);
      else           restart = sync_in || (tick && (m_tmr == {W{1'b1}}));
      flt = |fault_in;
      clr = wr_en && (wr_addr == 2'd3) && wr_data[0];
      m_irq <= (tick && (m_tmr == m_dact)) || (flt && !m_lat);
      if (restart) begin
        m_tmr <= '0; m_dact <= m_dbuf; m_pact <= m_pbuf;
      end else if (tick) m_tmr <= m_tmr + 1'b1;
      if (wr_en && wr_addr == 2'd0) m_dbuf <= wr_data;
      if (wr_en && wr_addr == 2'd1) m_pbuf <= wr_data;
      if (wr_en && wr_addr == 2'd2) m_ctrl <= wr_data[4:0];
      if (flt) m_lat <= 1'b1;
      else if (clr) m_lat <= 1'b0;
      if (m_lat && clr && !flt) m_wait <= 1'b1;
      else if (restart) m_wait <= 1'b0;
    end
  end

  task automatic idle();
    wr_en = 0; wr_addr = '0; wr_data = '0; tick = 0; sync_in = 0; fault_in = '0;
  endtask

  // Compare outputs with current inputs, then advance to next falling edge
  task automatic check(input string tag);
    logic forced, e_out, e_oe;
    #1;
    forced = (|fault_in) || m_lat || m_wait;
    e_oe   = !(forced && m_ctrl[3]);
    e_out  = forced ? m_ctrl[2] : (ref_wave(m_ctrl[0], m_tmr, m_dact) ^ m_ctrl[1]);
    n_vec++;
    if (pwm_out !== e_out || pwm_oe !== e_oe || irq !== m_irq) begin
      n_bad++;
      $display("FAIL %s%s: out=%b oe=%b irq=%b expected out=%b oe=%b irq=%b (tmr model %0d)",
               tag, (irq !== m_irq) ? "/R9" : "", pwm_out, pwm_oe, irq, e_out, e_oe, m_irq, m_tmr);
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d, input string tag);
    wr_en = 1; wr_addr = a; wr_data = d;
    check(tag);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic run(input int n, input int pct, input string tag);
    for (int i = 0; i < n; i++) begin
      tick = ($urandom % 100) < pct;
      check(tag);
    end
    tick = 0;
  endtask

  initial begin
    #1900000;
    n_bad++;
    $display("FAIL watchdog: run hung, got no end, expected finish");
    if (!done) $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R10");                       // reset state
    check("R10");

    // Edge shape, on-time 0 -> constant low (R1)
    wr(2'd2, 16'h0010, "R4");
    wr(2'd1, 16'd5, "R3");
    wr(2'd0, 16'd0, "R3");
    run(30, 100, "R1");
    // On-time beyond cycle -> constant high (R1)
    wr(2'd0, 16'd9, "R3");
    run(30, 100, "R1");
    // Mid-cycle on-time rewrite takes effect only on restart (R3)
    wr(2'd0, 16'd2, "R3");
    run(4, 100, "R3");
    wr(2'd0, 16'd4, "R3");
    run(20, 100, "R3");
    // Inversion (R7)
    wr(2'd2, 16'h0012, "R7");
    run(20, 70, "R7");
    // Center shape (R2)
    wr(2'd2, 16'h0011, "R2");
    wr(2'd1, 16'd7, "R3");
    wr(2'd0, 16'd3, "R2");
    run(40, 100, "R2");
    // Self-sync ignores sync_in (R4)
    sync_in = 1; run(10, 100, "R4"); sync_in = 0;

    // External restart and wrap-around (R5)
    wr(2'd2, 16'h0000, "R5");
    wr(2'd0, 16'd100, "R5");
    run(30, 100, "R5");
    sync_in = 1; check("R5"); sync_in = 0;
    run(20, 50, "R5");
    sync_in = 1; check("R5"); sync_in = 0;
    run(65560, 100, "R5");

    // Faults: level drive then tristate (R6, R8, R9)
    wr(2'd2, 16'h0014, "R6");
    wr(2'd1, 16'd9, "R3");
    wr(2'd0, 16'd3, "R1");
    run(15, 100, "R1");
    fault_in = 2'b01; run(3, 100, "R6");
    fault_in = 2'b00; run(5, 100, "R8");
    fault_in = 2'b10; tick = 1; wr(2'd3, 16'd1, "R8");   // clear refused while active
    fault_in = 2'b00; run(4, 100, "R8");
    tick = 1; wr(2'd3, 16'd1, "R8");                      // accepted
    run(25, 100, "R8");
    wr(2'd2, 16'h0018, "R6");
    fault_in = 2'b11; run(4, 100, "R6");
    fault_in = 2'b00; tick = 1; wr(2'd3, 16'd1, "R8");
    run(25, 100, "R8");

    // Constrained random mix
    for (int blk = 0; blk < 40; blk++) begin
      logic [W-1:0] per;
      per = W'(2 + $urandom % 29);
      wr(2'd2, W'($urandom % 32) | 16'h0010, "R4");
      wr(2'd1, per, "R3");
      wr(2'd0, W'($urandom % (32'(per) + 3)), "R3");
      for (int i = 0; i < 150; i++) begin
        tick = ($urandom % 100) < 75;
        fault_in = (($urandom % 100) < 2) ? NF'($urandom) : '0;
        if (($urandom % 100) < 3) begin
          wr_en = 1; wr_addr = 2'(($urandom % 2) ? 0 : 3);
          wr_data = (wr_addr == 2'd3) ? 16'd1 : W'($urandom % (32'(per) + 3));
        end
        check("R1");
        wr_en = 0; wr_data = '0; fault_in = '0;
      end
      fault_in = '0; wr(2'd3, 16'd1, "R8");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule